// File: doc/BRIEF.md
# Display FIFO Panic Watermark Generator

This block sits between a memory fetch engine and a pixel output stage. It holds the fetched pixel words in a small first-in first-out buffer and watches how full that buffer is. When the fill level sinks too low, it raises a priority request ("panic") toward the memory interconnect so that the fetch side is served sooner. The request then stays up until the buffer has refilled to a second, higher mark. Between the two marks the request keeps whatever value it had, so it does not toggle on every word that enters or leaves.

Both marks are programmed as fields of one threshold word. Each field is a value inside a fixed threshold range, and the block scales that value onto the buffer depth. A control word carries the enable bit and a write-one-to-clear bit for a sticky underflow flag. The flag records any read attempted while the buffer was empty.

Top module: `fifo_panic_gen`

## Requirements
- R1: After reset, panic is 0, the buffer is empty (empty=1, fill_level=0), underflow is 0, and the enable bit is 0.
- R2: The threshold word is written at cfg_addr=0, with the low field in bits [7:0] and the high field in bits [15:8]. After reset these fields hold RANGE/3 and 2*RANGE/3. A field value f maps to the fill count f*DEPTH/RANGE, clamped to DEPTH. With DEPTH=24 and RANGE=48 the default counts are 8 and 16.
- R3: While enabled, a fill level strictly below the low count sets the panic state. A fill level equal to the low count does not set it.
- R4: While enabled, a fill level at or above the high count clears the panic state, unless the fill is also below the low count.
- R5: While the fill level is at or above the low count and below the high count, panic keeps its previous value.
- R6: Panic is computed from the registered fill level. It changes in the cycle after the fill level crosses a threshold.
- R7: The enable bit is bit 0 of the control word at cfg_addr=1. When a write clears it, panic goes low in the cycle after that write and the hysteresis state resets. After re-enabling with the fill between the marks, panic stays low.
- R8: A new threshold word takes effect on the comparisons made from the cycle after the write.
- R9: A high field equal to RANGE maps to the full depth, so panic stays asserted until the buffer is completely full.
- R10: A write while the buffer is full is dropped. The fill level and the stored contents are unchanged.
- R11: Words are read out in the order they were written, and rd_data shows the oldest stored word whenever the buffer is not empty.
- R12: A read while the buffer is empty sets a sticky underflow flag and does not change the fill level. Writing 1 to bit 1 of the control word clears the flag. A new underflow event in the same cycle as a clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = threshold word, 1 = control word |
| cfg_wdata | input | 16 | Configuration write data |
| wr_en | input | 1 | Push a word from the memory fetch side |
| wr_data | input | DATA_W | Word to push |
| full | output | 1 | Buffer holds DEPTH words |
| rd_en | input | 1 | Pop a word toward the pixel side |
| rd_data | output | DATA_W | Oldest stored word |
| empty | output | 1 | Buffer holds no words |
| fill_level | output | $clog2(DEPTH+1) | Registered word count |
| panic | output | 1 | Priority request to the interconnect |
| underflow | output | 1 | Sticky flag for a read from an empty buffer |

## Verification
The bench targets the exact edges of the hysteresis band:
- A fill equal to the low count must leave panic low. A design that compares with "at or below" would raise it one word early.
- A fill one below the high count must keep panic high. A design that drops the request there would release one word early.
- The one-cycle latency after a crossing is sampled directly, so a design that compares against the next-state count shows up as a change one cycle early.

Disabling the block while the fill sits between the marks and then re-enabling it exposes a design that keeps its old hysteresis state. A full-range high mark shows whether the scaling and clamping let panic hold until the buffer is full. A push into a full buffer, followed by a scoreboard drain, would reveal a design that overwrites stored data. A read on an empty buffer checks that the underflow flag is sticky and that the fill level does not wrap.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  // width of one threshold field inside the threshold word
  localparam int TW = 8;

  typedef enum logic {
    CFG_THR  = 1'b0,
    CFG_CTRL = 1'b1
  } cfg_sel_e;

  // threshold word layout: high mark in the upper field, low mark in the lower
  typedef struct packed {
    logic [TW-1:0] hi;
    logic [TW-1:0] lo;
  } thr_word_t;
endpackage

// File: rtl/fpw_fifo.sv
module fpw_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 24,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic wr_ok, rd_ok;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = wr_en & ~full;
  assign rd_ok = rd_en & ~empty;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (wr_ok) wp_n = bump(wp_q);
    if (rd_ok) rp_n = bump(rp_q);
    case ({wr_ok, rd_ok})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  // storage carries no reset; written only under its enable
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

  assign rd_data = mem[rp_q];
  assign count   = cnt_q;

  // R10: a push into a full buffer without a pop leaves the count alone
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (count == $past(count)));

  // R11: the count never exceeds the depth
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= CW'(DEPTH)));

  // R12: a pop from an empty buffer does not wrap the count
  a_r12_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> (count == '0));
endmodule

// File: rtl/fpw_cfg.sv
module fpw_cfg
  import fpw_pkg::*;
#(
  parameter int DEPTH = 24,
  parameter int RANGE = 48,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            addr,
  input  logic [2*TW-1:0] wdata,
  input  logic            uf_evt,
  output logic            en,
  output logic [CW-1:0]   lo_cnt,
  output logic [CW-1:0]   hi_cnt,
  output logic            uf_flag
);
  localparam logic [TW-1:0] LO_DEF = TW'(RANGE / 3);
  localparam logic [TW-1:0] HI_DEF = TW'((2 * RANGE) / 3);

  thr_word_t thr_q, thr_n;
  logic en_q, en_n, uf_q, uf_n;
  logic thr_wr, ctl_wr, uf_clr;
  logic unused_ctrl_bits;

  assign thr_wr = we && (cfg_sel_e'(addr) == CFG_THR);
  assign ctl_wr = we && (cfg_sel_e'(addr) == CFG_CTRL);
  assign uf_clr = ctl_wr && wdata[1];
  assign unused_ctrl_bits = ^wdata[2*TW-1:2];

  always_comb begin
    thr_n = thr_q;
    en_n  = en_q;
    uf_n  = uf_q;
    if (thr_wr) thr_n = thr_word_t'(wdata);
    if (ctl_wr) en_n = wdata[0];
    if (uf_clr) uf_n = 1'b0;
    if (uf_evt) uf_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '{hi: HI_DEF, lo: LO_DEF};
      en_q  <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      thr_q <= thr_n;
      en_q  <= en_n;
      uf_q  <= uf_n;
    end
  end

  // scale a field onto the buffer depth, clamped to a full buffer
  function automatic logic [CW-1:0] to_cnt(input logic [TW-1:0] f);
    int unsigned v;
    v = (32'(f) * 32'(DEPTH)) / 32'(RANGE);
    if (v > 32'(DEPTH)) v = 32'(DEPTH);
    return CW'(v);
  endfunction

  assign lo_cnt  = to_cnt(thr_q.lo);
  assign hi_cnt  = to_cnt(thr_q.hi);
  assign en      = en_q;
  assign uf_flag = uf_q;

  // R12: an underflow event always leaves the flag set
  a_r12_uf_set: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> uf_flag);

  // R12: without a clear the flag holds
  a_r12_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_flag && !uf_clr) |=> uf_flag);

  // R2: scaled marks never pass the depth
  a_r2_marks_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt <= CW'(DEPTH)) && (hi_cnt <= CW'(DEPTH)));
endmodule

// File: rtl/fpw_hyst.sv
module fpw_hyst #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] lo_cnt,
  input  logic [CW-1:0] hi_cnt,
  output logic          panic
);
  logic st_q, st_n;
  logic below_lo, at_hi;

  assign below_lo = (fill < lo_cnt);
  assign at_hi    = (fill >= hi_cnt);

  always_comb begin
    st_n = st_q;
    if (!en)          st_n = 1'b0;
    else if (below_lo) st_n = 1'b1;
    else if (at_hi)    st_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= st_n;
  end

  assign panic = en & st_q;

  // R7: a disabled block never requests priority
  a_r7_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !panic);

  // R3: a fill below the low mark raises the request next cycle
  a_r3_raise_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en && below_lo) |=> st_q);

  // R4: reaching the high mark drops the request next cycle
  a_r4_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && at_hi && !below_lo) |=> !st_q);

  // R5: inside the band the state holds
  a_r5_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !below_lo && !at_hi) |=> (st_q == $past(st_q)));
endmodule

// File: rtl/fifo_panic_gen.sv
module fifo_panic_gen
  import fpw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 24,
  parameter int RANGE  = 48,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [2*TW-1:0]   cfg_wdata,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic [CW-1:0]     fill_level,
  output logic              panic,
  output logic              underflow
);
  logic [1:0] rst_sync_q;
  logic rst_ni;
  logic en;
  logic [CW-1:0] lo_cnt, hi_cnt;
  logic uf_evt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  fpw_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .full    (full),
    .empty   (empty),
    .count   (fill_level)
  );

  assign uf_evt = rd_en & empty;

  fpw_cfg #(.DEPTH(DEPTH), .RANGE(RANGE)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_ni),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .uf_evt  (uf_evt),
    .en      (en),
    .lo_cnt  (lo_cnt),
    .hi_cnt  (hi_cnt),
    .uf_flag (underflow)
  );

  fpw_hyst #(.CW(CW)) u_hyst (
    .clk    (clk),
    .rst_n  (rst_ni),
    .en     (en),
    .fill   (fill_level),
    .lo_cnt (lo_cnt),
    .hi_cnt (hi_cnt),
    .panic  (panic)
  );

  // R1: while held in reset the request and the flag stay low
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_ni |=> (!panic && !underflow));
endmodule

// File: tb/fifo_panic_gen_tb.sv
module fifo_panic_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEPTH = 24;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk, rst_n;
  logic cfg_we, cfg_addr;
  logic [15:0] cfg_wdata;
  logic wr_en, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic full, empty, panic, underflow;
  logic [CW-1:0] fill_level;

  int n_chk = 0;
  int n_fail = 0;
  int m_cnt = 0;
  logic [DW-1:0] sb_q[$];
  logic [DW-1:0] seq = 16'h1000;
  bit done = 0;

  fifo_panic_gen #(.DATA_W(DW), .DEPTH(DEPTH), .RANGE(48)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .fill_level(fill_level),
    .panic(panic), .underflow(underflow)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares each popped word against the scoreboard
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && rd_en && !empty) begin
      if (sb_q.size() == 0) chk("R11 unexpected word", 1, 0);
      else chk("R11 read order", int'(rd_data), int'(sb_q.pop_front()));
    end
  end

  task automatic push();
    wr_en = 1; wr_data = seq;
    if (m_cnt < DEPTH) begin sb_q.push_back(seq); m_cnt++; end
    seq = seq + 16'h0011;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pop();
    rd_en = 1;
    if (m_cnt > 0) m_cnt--;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_wr(input logic a, input logic [15:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    wr_en = 0; rd_en = 0; wr_data = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    // R1 reset state
    chk("R1 panic", panic, 0);
    chk("R1 empty", empty, 1);
    chk("R1 fill", fill_level, 0);
    chk("R1 underflow", underflow, 0);

    // R2 defaults (low 8, high 16), R3 raise below low
    cfg_wr(1'b1, 16'h0001);
    idle(1);
    chk("R3 R2 raise on empty", panic, 1);
    for (int i = 0; i < 15; i++) push();
    idle(1);
    chk("R5 hold inside band at 15", panic, 1);
    push();
    chk("R6 latency at reaching 16", panic, 1);
    idle(1);
    chk("R4 R2 release at high 16", panic, 0);

    for (int i = 0; i < 8; i++) pop();
    idle(1);
    chk("R3 equal to low keeps low", panic, 0);
    pop();
    chk("R6 latency below low", panic, 0);
    idle(1);
    chk("R3 raise at 7", panic, 1);

    // R7 disable inside band, then re-enable
    for (int i = 0; i < 3; i++) push();
    chk("R5 hold high at 10", panic, 1);
    cfg_wr(1'b1, 16'h0000);
    chk("R7 disable drops panic", panic, 0);
    idle(1);
    cfg_wr(1'b1, 16'h0001);
    idle(2);
    chk("R7 state reset after re-enable", panic, 0);

    // R8 new marks low 32 (16), high 48 (24)
    cfg_wr(1'b0, 16'h3020);
    idle(2);
    chk("R8 new low mark raises", panic, 1);
    for (int i = 0; i < 13; i++) push();
    idle(1);
    chk("R9 hold at 23 with full-range high", panic, 1);
    push();
    idle(1);
    chk("R9 release at full", panic, 0);
    chk("R10 full flag", full, 1);
    push();
    idle(1);
    chk("R10 write when full dropped", fill_level, 24);

    for (int i = 0; i < 24; i++) pop();
    idle(1);
    chk("R11 drained empty", empty, 1);
    chk("R11 scoreboard drained", sb_q.size(), 0);

    // R12 underflow
    pop();
    chk("R12 underflow set", underflow, 1);
    chk("R12 fill unchanged", fill_level, 0);
    idle(2);
    chk("R12 sticky", underflow, 1);
    cfg_wr(1'b1, 16'h0003);
    chk("R12 write-one clear", underflow, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule